// File: doc/BRIEF.md
# Slave FIFO External Port

This block lets an outside bus master move data in and out of four byte-wide endpoint FIFOs held inside the block. The master selects a FIFO with a two-bit address and controls the transfer with an active-low chip select and active-high read, write, output-enable and packet-end controls. Each FIFO is given a direction. Toward-USB FIFOs are filled by the outside master and drained byte by byte by an internal USB-side pop port. Toward-external FIFOs are filled by the USB-side push port and drained by the outside master.

A mode input picks how the strobes are interpreted. In synchronous mode, read, write and packet-end are enables sampled on each rising edge of the interface clock. In asynchronous mode, each rising edge of a strobe is one transfer, detected through a two-flop synchronizer. Each FIFO can be set to 8-bit or 16-bit transfers on its own. Every FIFO reports empty, full and programmable-level flags, and any of these flags can drive the interrupt output through a mask.

Bytes written by the outside master do not reach the USB side until a packet is committed. A packet is committed when `PKT` bytes have built up, or when the master pulses packet-end, which also sends a short packet.

Top module: `slave_fifo_port`

## Requirements
- R1: After reset every FIFO holds zero bytes: `flag_empty` is 4'b1111, `flag_full` is 4'b0000 and `usb_ready` is 0.
- R2: While `cs_n` is high, the read, write, output-enable and packet-end inputs have no effect. No pointer moves, no packet is committed and `dout_oe` is 2'b00.
- R3: In synchronous mode, a write seen with `cs_n` low at a rising clock edge stores `din` into the FIFO numbered by `fifo_sel` (0 to 3). A read seen the same way removes the head. The head of the selected FIFO is visible on `dout` before the read edge.
- R4: In asynchronous mode, each rising edge of a chip-select-gated strobe performs exactly one transfer, at the third rising clock edge after the strobe rises. A strobe held high for many cycles still counts once.
- R5: A write to a full FIFO and a read from an empty FIFO are ignored. In byte mode, full means DEPTH bytes stored and empty means 0 bytes stored. In word mode, full means fewer than 2 bytes free and empty means fewer than 2 bytes stored. A USB-side push into a FIFO holding DEPTH bytes is also ignored.
- R6: With `word_mode[i]` set, a write stores `din[7:0]` first and then `din[15:8]`. A read presents the older byte on `dout[7:0]` and the next byte on `dout[15:8]`, and moves the pointer by two bytes.
- R7: `dout_oe[0]` is high only while `cs_n` is low, `ext_oe` is high and `ext_wr` is low. `dout_oe[1]` additionally needs the selected FIFO to be in word mode. A disabled lane reads 0.
- R8: For a toward-USB FIFO, `usb_ready` and USB-side pops apply only to committed bytes. Bytes are committed once `PKT` uncommitted bytes have built up, or when a packet-end event occurs on the selected toward-USB FIFO.
- R9: `flag_level[i]` is high when FIFO i holds at least `level_mark` bytes. `irq` is the OR of {`flag_level`, `flag_full`, `flag_empty`} ANDed with `irq_mask`: bits 3:0 mask empty, bits 7:4 mask full and bits 11:8 mask level, where bit position within each group equals the FIFO number.
- R10: The direction bit `to_usb[i]` (1 = toward USB) limits access. The external side can only write toward-USB FIFOs and only read the others. The USB side can only push toward-external FIFOs and only pop toward-USB FIFOs. Any other access is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| async_mode | input | 1 | 1 = strobes act as edges, 0 = strobes are clock enables |
| word_mode | input | 4 | Per-FIFO 16-bit transfer select |
| to_usb | input | 4 | Per-FIFO direction, 1 = external writes / USB reads |
| level_mark | input | PW | Byte count at which the level flag rises |
| irq_mask | input | 12 | Interrupt mask over empty, full and level flags |
| cs_n | input | 1 | Active-low chip select gating all controls |
| fifo_sel | input | 2 | FIFO addressed by the external side |
| ext_rd | input | 1 | Read strobe |
| ext_wr | input | 1 | Write strobe |
| ext_oe | input | 1 | Output enable for the data lanes |
| pkt_end | input | 1 | Commit a short packet |
| din | input | 16 | Write data |
| dout | output | 16 | Head data of the selected FIFO |
| dout_oe | output | 2 | Per-byte-lane drive enable |
| usb_sel | input | 2 | FIFO addressed by the USB side |
| usb_push | input | 1 | USB-side byte push |
| usb_wdata | input | 8 | USB-side push data |
| usb_pop | input | 1 | USB-side byte pop |
| usb_rdata | output | 8 | Head byte for the USB side |
| usb_ready | output | 1 | Committed byte available to pop |
| flag_empty | output | 4 | Per-FIFO empty flag |
| flag_full | output | 4 | Per-FIFO full flag |
| flag_level | output | 4 | Per-FIFO level flag |
| irq | output | 1 | Masked flag interrupt request |

## Verification
The hardest case to reach is a word-mode FIFO left holding an odd byte count. No external transfer can create that state, because external writes and reads always move two bytes. The stimulus gets there by pushing single bytes through the USB side, and by mixing random USB pushes and pops with external word reads. The bench then checks that the word-mode empty flag rises with one byte left and that a read in that state is ignored. Asynchronous strobes are held high for several clock cycles so that a design acting on the level instead of the edge would store repeated bytes.

// File: rtl/slave_fifo_port.sv
module slave_fifo_port #(
  parameter int DEPTH = 16,
  parameter int PKT   = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          async_mode,
  input  logic [3:0]    word_mode,
  input  logic [3:0]    to_usb,
  input  logic [PW-1:0] level_mark,
  input  logic [11:0]   irq_mask,
  input  logic          cs_n,
  input  logic [1:0]    fifo_sel,
  input  logic          ext_rd,
  input  logic          ext_wr,
  input  logic          ext_oe,
  input  logic          pkt_end,
  input  logic [15:0]   din,
  output logic [15:0]   dout,
  output logic [1:0]    dout_oe,
  input  logic [1:0]    usb_sel,
  input  logic          usb_push,
  input  logic [7:0]    usb_wdata,
  input  logic          usb_pop,
  output logic [7:0]    usb_rdata,
  output logic          usb_ready,
  output logic [3:0]    flag_empty,
  output logic [3:0]    flag_full,
  output logic [3:0]    flag_level,
  output logic          irq
);

  logic [7:0]    mem  [4][DEPTH];
  logic [PW-1:0] wp   [4];
  logic [PW-1:0] rp   [4];
  logic [PW-1:0] cp   [4];
  logic [PW-1:0] cnt  [4];
  logic [PW-1:0] unit [4];
  logic [2:0]    rd_s, wr_s, pe_s;

  wire rd_g = ext_rd  & ~cs_n;
  wire wr_g = ext_wr  & ~cs_n;
  wire pe_g = pkt_end & ~cs_n;

  wire rd_ev = async_mode ? (rd_s[1] & ~rd_s[2]) : rd_g;
  wire wr_ev = async_mode ? (wr_s[1] & ~wr_s[2]) : wr_g;
  wire pe_ev = async_mode ? (pe_s[1] & ~pe_s[2]) : pe_g;

  always_comb
    for (int i = 0; i < 4; i++) begin
      cnt[i]        = wp[i] - rp[i];
      unit[i]       = word_mode[i] ? PW'(2) : PW'(1);
      flag_empty[i] = cnt[i] < unit[i];
      flag_full[i]  = (PW'(DEPTH) - cnt[i]) < unit[i];
      flag_level[i] = cnt[i] >= level_mark;
    end

  assign irq = |({flag_level, flag_full, flag_empty} & irq_mask);

  wire [PW-1:0] ew   = wp[fifo_sel];
  wire [PW-1:0] er   = rp[fifo_sel];
  wire [PW-1:0] eu   = unit[fifo_sel];
  wire [PW-1:0] ew1  = ew + PW'(1);
  wire [PW-1:0] er1  = er + PW'(1);

  wire ext_w  = wr_ev & to_usb[fifo_sel] & ~flag_full[fifo_sel];
  wire ext_r  = rd_ev & ~to_usb[fifo_sel] & ~flag_empty[fifo_sel];
  wire ext_c  = pe_ev & to_usb[fifo_sel];
  wire [PW-1:0] ew_n = ext_w ? ew + eu : ew;
  wire commit = ext_c | (ext_w & ((ew_n - cp[fifo_sel]) >= PW'(PKT)));

  wire usb_w = usb_push & ~to_usb[usb_sel] & (cnt[usb_sel] != PW'(DEPTH));
  assign usb_ready = to_usb[usb_sel] & (rp[usb_sel] != cp[usb_sel]);
  wire usb_r = usb_pop & usb_ready;

  wire [7:0] head_lo = mem[fifo_sel][er[AW-1:0]];
  wire [7:0] head_hi = mem[fifo_sel][er1[AW-1:0]];

  assign dout_oe[0] = ~cs_n & ext_oe & ~ext_wr;
  assign dout_oe[1] = dout_oe[0] & word_mode[fifo_sel];
  assign dout       = {dout_oe[1] ? head_hi : 8'h00, dout_oe[0] ? head_lo : 8'h00};
  assign usb_rdata  = mem[usb_sel][rp[usb_sel][AW-1:0]];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_s <= '0;
      wr_s <= '0;
      pe_s <= '0;
      for (int i = 0; i < 4; i++) begin
        wp[i] <= '0;
        rp[i] <= '0;
        cp[i] <= '0;
      end
    end else begin
      rd_s <= {rd_s[1:0], rd_g};
      wr_s <= {wr_s[1:0], wr_g};
      pe_s <= {pe_s[1:0], pe_g};
      if (ext_w)  wp[fifo_sel] <= ew_n;
      if (usb_w)  wp[usb_sel]  <= wp[usb_sel] + PW'(1);
      if (ext_r)  rp[fifo_sel] <= er + eu;
      if (usb_r)  rp[usb_sel]  <= rp[usb_sel] + PW'(1);
      if (commit) cp[fifo_sel] <= ew_n;
    end

  always_ff @(posedge clk) begin
    if (ext_w) begin
      mem[fifo_sel][ew[AW-1:0]] <= din[7:0];
      if (word_mode[fifo_sel]) mem[fifo_sel][ew1[AW-1:0]] <= din[15:8];
    end
    if (usb_w) mem[usb_sel][wp[usb_sel][AW-1:0]] <= usb_wdata;
  end

endmodule

// File: rtl/slave_fifo_port_chk.sv
module slave_fifo_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       async_mode,
  input logic       cs_n,
  input logic       ext_wr,
  input logic [1:0] fifo_sel,
  input logic [3:0] word_mode,
  input logic [3:0] to_usb,
  input logic       usb_push,
  input logic       usb_pop,
  input logic [1:0] dout_oe,
  input logic [3:0] flag_empty,
  input logic [3:0] flag_full
);

  a_r2_no_drive_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> dout_oe == 2'b00);

  a_r2_deselected_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!async_mode && cs_n && !usb_push && !usb_pop)
    |=> (!$stable(word_mode) || ($stable(flag_empty) && $stable(flag_full))));

  a_r5_empty_full_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_empty & flag_full) == 4'b0000);

  a_r5_full_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!async_mode && !cs_n && ext_wr && to_usb[fifo_sel] && flag_full[fifo_sel] && !usb_pop)
    |=> (!$stable(fifo_sel) || !$stable(word_mode) || flag_full[fifo_sel]));

  a_r7_high_lane_word_only: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe[1] |-> (dout_oe[0] && word_mode[fifo_sel]));

endmodule

bind slave_fifo_port slave_fifo_port_chk u_chk (.*);

// File: tb/tb_slave_fifo_port.sv
module tb_slave_fifo_port;
  localparam int DEPTH = 16;
  localparam int PKT   = 8;
  localparam int PW    = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, async_mode, cs_n, ext_rd, ext_wr, ext_oe, pkt_end;
  logic [3:0]    word_mode, to_usb;
  logic [PW-1:0] level_mark;
  logic [11:0]   irq_mask;
  logic [1:0]    fifo_sel, usb_sel, dout_oe;
  logic [15:0]   din, dout;
  logic          usb_push, usb_pop, usb_ready, irq;
  logic [7:0]    usb_wdata, usb_rdata;
  logic [3:0]    flag_empty, flag_full, flag_level;

  slave_fifo_port #(.DEPTH(DEPTH), .PKT(PKT)) dut (.*);

  int n_chk = 0, n_bad = 0;
  logic [7:0] q [4][$];
  int cm [4];

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic int unitf(int i);
    return word_mode[i] ? 2 : 1;
  endfunction

  task automatic check_state(string tag);
    logic [3:0] e, f, l;
    for (int i = 0; i < 4; i++) begin
      e[i] = q[i].size() < unitf(i);
      f[i] = (DEPTH - q[i].size()) < unitf(i);
      l[i] = q[i].size() >= int'(level_mark);
    end
    chk({tag, " R5 empty"}, flag_empty, e);
    chk({tag, " R5 full"}, flag_full, f);
    chk({tag, " R9 level"}, flag_level, l);
    chk({tag, " R9 irq"}, irq, |({l, f, e} & irq_mask));
    chk({tag, " R8 ready"}, usb_ready, to_usb[usb_sel] && cm[usb_sel] > 0);
  endtask

  task automatic strobe(int kind, bit sel);
    cs_n = !sel;
    case (kind)
      0: ext_wr = 1'b1;
      1: ext_rd = 1'b1;
      default: pkt_end = 1'b1;
    endcase
    if (async_mode) repeat (4) @(posedge clk);
    else @(posedge clk);
    #1;
    ext_wr = 1'b0; ext_rd = 1'b0; pkt_end = 1'b0; cs_n = 1'b1;
    if (async_mode) begin
      repeat (4) @(posedge clk);
      #1;
    end
    #1;
  endtask

  task automatic ext_write(int sel, logic [15:0] d);
    fifo_sel = 2'(sel); din = d;
    strobe(0, 1'b1);
    if (to_usb[sel] && (DEPTH - q[sel].size()) >= unitf(sel)) begin
      q[sel].push_back(d[7:0]);
      if (word_mode[sel]) q[sel].push_back(d[15:8]);
      if (q[sel].size() - cm[sel] >= PKT) cm[sel] = q[sel].size();
    end
  endtask

  task automatic ext_read(int sel, string tag);
    logic [15:0] exp;
    fifo_sel = 2'(sel); cs_n = 1'b0; ext_oe = 1'b1;
    #1;
    if (!to_usb[sel] && q[sel].size() >= unitf(sel)) begin
      exp = word_mode[sel] ? {q[sel][1], q[sel][0]} : {8'h00, q[sel][0]};
      chk({tag, " R3/R6 head data"}, dout, exp);
    end
    ext_oe = 1'b0; cs_n = 1'b1;
    strobe(1, 1'b1);
    if (!to_usb[sel] && q[sel].size() >= unitf(sel))
      repeat (unitf(sel)) void'(q[sel].pop_front());
  endtask

  task automatic pkt(int sel);
    fifo_sel = 2'(sel);
    strobe(2, 1'b1);
    if (to_usb[sel]) cm[sel] = q[sel].size();
  endtask

  task automatic u_push(int sel, logic [7:0] d);
    usb_sel = 2'(sel); usb_wdata = d; usb_push = 1'b1;
    @(posedge clk); #1;
    usb_push = 1'b0;
    #1;
    if (!to_usb[sel] && q[sel].size() < DEPTH) q[sel].push_back(d);
  endtask

  task automatic u_pop(int sel, string tag);
    usb_sel = 2'(sel);
    #1;
    if (to_usb[sel] && cm[sel] > 0) chk({tag, " R8 usb data"}, usb_rdata, q[sel][0]);
    usb_pop = 1'b1;
    @(posedge clk); #1;
    usb_pop = 1'b0;
    #1;
    if (to_usb[sel] && cm[sel] > 0) begin
      void'(q[sel].pop_front());
      cm[sel]--;
    end
  endtask

  task automatic deselected_storm(int sel);
    fifo_sel = 2'(sel); din = 16'hdead; cs_n = 1'b1;
    ext_wr = 1'b1; ext_rd = 1'b1; pkt_end = 1'b1; ext_oe = 1'b1;
    #1;
    chk("R2 lanes off while deselected", dout_oe, 2'b00);
    @(posedge clk); #1;
    ext_wr = 1'b0; ext_rd = 1'b0; pkt_end = 1'b0; ext_oe = 1'b0;
    #1;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    rst_n = 1'b0; async_mode = 1'b0; cs_n = 1'b1; ext_rd = 1'b0; ext_wr = 1'b0;
    ext_oe = 1'b0; pkt_end = 1'b0; word_mode = 4'b1100; to_usb = 4'b0101;
    level_mark = 5'd6; irq_mask = 12'h0; fifo_sel = 2'd0; usb_sel = 2'd0; din = '0;
    usb_push = 1'b0; usb_pop = 1'b0; usb_wdata = '0;
    for (int i = 0; i < 4; i++) cm[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #2;

    chk("R1 reset empty", flag_empty, 4'b1111);
    chk("R1 reset full", flag_full, 4'b0000);
    chk("R1 reset ready", usb_ready, 1'b0);
    check_state("R1 reset");

    for (int k = 0; k < 5; k++) ext_write(0, 16'(8'h10 + k));
    check_state("R3 byte writes uncommitted R8");
    pkt(0);
    check_state("R8 after packet end");
    for (int k = 0; k < 5; k++) u_pop(0, "R8 short packet");
    check_state("R8 drained");

    ext_write(0, 16'h0077);
    deselected_storm(0);
    deselected_storm(1);
    check_state("R2 deselected strobes");
    u_pop(0, "R2 pop without commit");
    check_state("R2 after pop attempt");

    ext_write(1, 16'h00aa);
    u_push(0, 8'h55);
    check_state("R10 wrong-direction access");

    for (int k = 0; k < DEPTH; k++) u_push(1, 8'(k * 7 + 3));
    check_state("R5 fifo1 full");
    u_push(1, 8'hee);
    check_state("R5 push to full ignored");
    for (int k = 0; k < DEPTH; k++) ext_read(1, "R3 byte read");
    ext_read(1, "R5 read empty");
    check_state("R5 read from empty ignored");

    for (int k = 0; k < 9; k++) ext_write(2, {8'(8'h80 + 2 * k + 1), 8'(8'h80 + 2 * k)});
    check_state("R6 word fill with overflow write");
    for (int k = 0; k < DEPTH; k++) u_pop(2, "R6 word byte order");
    check_state("R6 word drained");

    u_push(3, 8'h31); u_push(3, 8'h32); u_push(3, 8'h33);
    fifo_sel = 2'd3; cs_n = 1'b0; ext_oe = 1'b1; #1;
    chk("R7 word lanes", dout_oe, 2'b11);
    ext_wr = 1'b1; #1;
    chk("R7 lanes off during write", dout_oe, 2'b00);
    ext_wr = 1'b0; fifo_sel = 2'd1; #1;
    chk("R7 byte lane only", dout_oe, 2'b01);
    chk("R7 idle high lane zero", dout[15:8], 8'h00);
    ext_oe = 1'b0; cs_n = 1'b1; #1;
    ext_read(3, "R6 word read");
    check_state("R6 one byte left in word fifo");
    ext_read(3, "R6 odd byte read");
    check_state("R5 word read ignored on one byte");
    u_push(3, 8'h34);
    ext_read(3, "R6 word read after refill");
    check_state("R6 word fifo emptied");

    async_mode = 1'b1;
    for (int k = 0; k < 3; k++) ext_write(0, 16'(8'hc0 + k));
    check_state("R4 async held strobes");
    pkt(0);
    check_state("R4 async packet end");
    for (int k = 0; k < 4; k++) u_pop(0, "R4 async data");
    for (int k = 0; k < 4; k++) u_push(1, 8'(8'h60 + k));
    ext_read(1, "R4 async read");
    ext_read(1, "R4 async read");
    check_state("R4 async reads once each");
    async_mode = 1'b0;

    for (int it = 0; it < 400; it++) begin
      int op, sel;
      op = $urandom % 6;
      sel = $urandom % 4;
      irq_mask = 12'($urandom);
      level_mark = PW'($urandom % 17);
      case (op)
        0: ext_write(sel, 16'($urandom));
        1: ext_read(sel, "R3 random read");
        2: u_push(sel, 8'($urandom));
        3: u_pop(sel, "R8 random pop");
        4: pkt(sel);
        default: deselected_storm(sel);
      endcase
      check_state("R9 random");
    end

    finish_run();
  end
endmodule